// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block sits between one pipeline access port and a simple word-wide memory port. It keeps lines of two 32-bit words (8 bytes) in two ways per set, and the number of sets is set by the index-width parameter. A read that finds its line is answered in the same cycle with no stall. A read that misses holds the requester stalled while the line is brought in from memory one word at a time. Once the line is in place, the held request hits and its word is returned.

Every store goes to memory at once (write-through). A store that finds its line also updates the cached copy under its byte enables. A store that misses leaves the cache unchanged. Replacement keeps one least-recently-used bit per set.

A stage-hold vector is derived from the single stall. In instruction-cache use it holds only the fetch stage. In data-cache use it holds every stage except the last one (writeback).

Top module: `c2w_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address misses. With no request in the idle state, `stall` and `mem_valid` are low.
- R2: A read that hits drives `rsp_valid` high, `stall` low and the addressed word on `rsp_rdata` in the same cycle. Address bit 2 selects word 0 or word 1 of the line.
- R3: A read miss raises `stall` in the cycle the miss is seen and keeps it high through the whole refill. In the cycle after the second refill word is accepted, `stall` is low and `rsp_rdata` carries the requested word.
- R4: A refill issues two memory reads (`mem_write` low, `mem_be` all ones), first to the line's word at offset 0 and then to offset 4. Each read keeps `mem_valid` high and its address unchanged until a cycle with `mem_ready` high, and `mem_rdata` is taken in that cycle.
- R5: A store drives `mem_valid` and `mem_write` high in the same cycle, with the word-aligned request address, `req_wdata` and `req_be`. `stall` stays high until a cycle with `mem_ready` high, and in that cycle `stall` is low.
- R6: A store hit merges the bytes whose `req_be` bit is set (bit b covers data bits 8b+7:8b) into the cached word. A store miss allocates nothing, so a later read of that line misses.
- R7: A refill goes to way 0 if way 0 is invalid, else to way 1 if way 1 is invalid, else to the way named by the set's LRU bit. A read hit, a store hit or a refill into way w sets the LRU bit to the other way.
- R8: With `DCACHE`=1, bits NSTAGE-2..0 of `stall_stages` follow `stall` and bit NSTAGE-1 (writeback) stays low. With `DCACHE`=0, only bit 0 (fetch) follows `stall`.
- R9: The address is split into byte offset [2:0], set index [IDX_W+2:3] and tag above that. Lines with different index bits never evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = store, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| rsp_valid | output | 1 | Read data valid this cycle |
| rsp_rdata | output | 32 | Read data |
| stall | output | 1 | Requester must hold its access |
| stall_stages | output | NSTAGE | Per-stage hold, fetch at bit 0 |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory write byte enables |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ready |

## Verification
The properties assume the requester keeps `req_valid`, `req_write`, `req_addr`, `req_wdata` and `req_be` unchanged while `stall` is high. For example, the check that the refill address stays fixed while memory is not ready only holds if the request address does not move. They also assume that `mem_ready` means completion in that same cycle. The stimulus changes request fields only at the end of a transaction, after `stall` has fallen. It raises `mem_ready` for exactly one cycle per memory word, after chosen waits of zero to three cycles.

// File: rtl/c2w_pkg.sv
package c2w_pkg;
    localparam int C2W_WAYS  = 2;
    localparam int C2W_WORDS = 2;
    localparam int C2W_DW    = 32;
    localparam int C2W_BE_W  = C2W_DW / 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL0 = 2'd1,
        ST_FILL1 = 2'd2
    } fill_st_e;

    typedef struct packed {
        fill_st_e st;
        logic     way;
    } ctrl_t;
endpackage

// File: rtl/c2w_lookup.sv
module c2w_lookup
    import c2w_pkg::*;
#(
    parameter int TAG_W = 25
) (
    input  logic [TAG_W-1:0]          req_tag,
    input  logic [C2W_WAYS-1:0]       way_valid,
    input  logic [C2W_WAYS*TAG_W-1:0] way_tag,
    input  logic                      lru,
    output logic                      hit_any,
    output logic                      hit_way,
    output logic                      victim
);
    logic [C2W_WAYS-1:0] hit_vec;

    for (genvar w = 0; w < C2W_WAYS; w++) begin : g_cmp
        assign hit_vec[w] = way_valid[w] && (way_tag[w*TAG_W +: TAG_W] == req_tag);
    end

    always_comb begin
        hit_any = |hit_vec;
        hit_way = hit_vec[1];
        if (!way_valid[0]) begin
            victim = 1'b0;
        end else if (!way_valid[1]) begin
            victim = 1'b1;
        end else begin
            victim = lru;
        end
    end
endmodule

// File: rtl/c2w_store.sv
module c2w_store
    import c2w_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 25
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           idx,
    input  logic                       wsel,
    output logic [C2W_WAYS-1:0]        rd_valid,
    output logic [C2W_WAYS*TAG_W-1:0]  rd_tag,
    output logic [C2W_WAYS*C2W_DW-1:0] rd_word,
    output logic                       rd_lru,
    input  logic                       fill_we,
    input  logic                       fill_last,
    input  logic                       fill_way,
    input  logic                       fill_word,
    input  logic [C2W_DW-1:0]          fill_data,
    input  logic [TAG_W-1:0]           fill_tag,
    input  logic                       hit_we,
    input  logic                       hit_way,
    input  logic [C2W_DW-1:0]          hit_data,
    input  logic [C2W_BE_W-1:0]        hit_be,
    input  logic                       lru_we,
    input  logic                       lru_val
);
    localparam int SETS = 1 << IDX_W;

    logic              valid_q [C2W_WAYS][SETS];
    logic              valid_d [C2W_WAYS][SETS];
    logic [TAG_W-1:0]  tag_q   [C2W_WAYS][SETS];
    logic [TAG_W-1:0]  tag_d   [C2W_WAYS][SETS];
    logic [C2W_DW-1:0] data_q  [C2W_WAYS][SETS][C2W_WORDS];
    logic [C2W_DW-1:0] data_d  [C2W_WAYS][SETS][C2W_WORDS];
    logic              lru_q   [SETS];
    logic              lru_d   [SETS];

    for (genvar w = 0; w < C2W_WAYS; w++) begin : g_rd
        assign rd_valid[w]                  = valid_q[w][idx];
        assign rd_tag[w*TAG_W +: TAG_W]     = tag_q[w][idx];
        assign rd_word[w*C2W_DW +: C2W_DW]  = data_q[w][idx][wsel];
    end
    assign rd_lru = lru_q[idx];

    always_comb begin
        valid_d = valid_q;
        tag_d   = tag_q;
        data_d  = data_q;
        lru_d   = lru_q;
        if (fill_we) begin
            data_d[fill_way][idx][fill_word] = fill_data;
            if (fill_last) begin
                valid_d[fill_way][idx] = 1'b1;
                tag_d[fill_way][idx]   = fill_tag;
            end
        end
        if (hit_we) begin
            for (int b = 0; b < C2W_BE_W; b++) begin
                if (hit_be[b]) begin
                    data_d[hit_way][idx][wsel][8*b +: 8] = hit_data[8*b +: 8];
                end
            end
        end
        if (lru_we) begin
            lru_d[idx] = lru_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                lru_q[s] <= 1'b0;
                for (int w = 0; w < C2W_WAYS; w++) begin
                    valid_q[w][s] <= 1'b0;
                end
            end
        end else begin
            valid_q <= valid_d;
            lru_q   <= lru_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q  <= tag_d;
        data_q <= data_d;
    end
endmodule

// File: rtl/c2w_ctrl.sv
module c2w_ctrl
    import c2w_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic hit_any,
    input  logic hit_way,
    input  logic victim,
    input  logic mem_ready,
    output logic stall,
    output logic refilling,
    output logic mem_valid,
    output logic mem_write,
    output logic fill_we,
    output logic fill_last,
    output logic fill_way,
    output logic fill_word,
    output logic hit_we,
    output logic lru_we,
    output logic lru_val
);
    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        stall     = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        fill_we   = 1'b0;
        fill_last = 1'b0;
        fill_way  = ctl_q.way;
        fill_word = 1'b0;
        hit_we    = 1'b0;
        lru_we    = 1'b0;
        lru_val   = ~hit_way;
        refilling = (ctl_q.st != ST_IDLE);
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid && req_write) begin
                    mem_valid = 1'b1;
                    mem_write = 1'b1;
                    stall     = ~mem_ready;
                    if (mem_ready && hit_any) begin
                        hit_we = 1'b1;
                        lru_we = 1'b1;
                    end
                end else if (req_valid) begin
                    if (hit_any) begin
                        lru_we = 1'b1;
                    end else begin
                        stall      = 1'b1;
                        ctl_d.way  = victim;
                        ctl_d.st   = ST_FILL0;
                    end
                end
            end
            ST_FILL0: begin
                stall     = 1'b1;
                mem_valid = 1'b1;
                if (mem_ready) begin
                    fill_we  = 1'b1;
                    ctl_d.st = ST_FILL1;
                end
            end
            ST_FILL1: begin
                stall     = 1'b1;
                mem_valid = 1'b1;
                fill_word = 1'b1;
                if (mem_ready) begin
                    fill_we   = 1'b1;
                    fill_last = 1'b1;
                    lru_we    = 1'b1;
                    lru_val   = ~ctl_q.way;
                    ctl_d.st  = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, way: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/c2w_cache.sv
module c2w_cache
    import c2w_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int NSTAGE = 5,
    parameter bit DCACHE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [C2W_DW-1:0]   req_wdata,
    input  logic [C2W_BE_W-1:0] req_be,
    output logic                rsp_valid,
    output logic [C2W_DW-1:0]   rsp_rdata,
    output logic                stall,
    output logic [NSTAGE-1:0]   stall_stages,
    output logic                mem_valid,
    output logic                mem_write,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [C2W_DW-1:0]   mem_wdata,
    output logic [C2W_BE_W-1:0] mem_be,
    input  logic                mem_ready,
    input  logic [C2W_DW-1:0]   mem_rdata
);
    localparam int OFF_W = 3;
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [TAG_W-1:0]           req_tag;
    logic [IDX_W-1:0]           req_idx;
    logic                       req_wsel;
    logic [C2W_WAYS-1:0]        way_valid;
    logic [C2W_WAYS*TAG_W-1:0]  way_tag;
    logic [C2W_WAYS*C2W_DW-1:0] way_word;
    logic                       set_lru;
    logic                       hit_any, hit_way, victim;
    logic                       refilling;
    logic                       fill_we, fill_last, fill_way, fill_word;
    logic                       hit_we, lru_we, lru_val;

    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = req_addr[OFF_W +: IDX_W];
    assign req_wsel = req_addr[2];

    c2w_lookup #(.TAG_W(TAG_W)) u_lookup (
        .req_tag   (req_tag),
        .way_valid (way_valid),
        .way_tag   (way_tag),
        .lru       (set_lru),
        .hit_any   (hit_any),
        .hit_way   (hit_way),
        .victim    (victim)
    );

    c2w_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (req_idx),
        .wsel      (req_wsel),
        .rd_valid  (way_valid),
        .rd_tag    (way_tag),
        .rd_word   (way_word),
        .rd_lru    (set_lru),
        .fill_we   (fill_we),
        .fill_last (fill_last),
        .fill_way  (fill_way),
        .fill_word (fill_word),
        .fill_data (mem_rdata),
        .fill_tag  (req_tag),
        .hit_we    (hit_we),
        .hit_way   (hit_way),
        .hit_data  (req_wdata),
        .hit_be    (req_be),
        .lru_we    (lru_we),
        .lru_val   (lru_val)
    );

    c2w_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .hit_any   (hit_any),
        .hit_way   (hit_way),
        .victim    (victim),
        .mem_ready (mem_ready),
        .stall     (stall),
        .refilling (refilling),
        .mem_valid (mem_valid),
        .mem_write (mem_write),
        .fill_we   (fill_we),
        .fill_last (fill_last),
        .fill_way  (fill_way),
        .fill_word (fill_word),
        .hit_we    (hit_we),
        .lru_we    (lru_we),
        .lru_val   (lru_val)
    );

    always_comb begin
        rsp_valid = req_valid && !req_write && hit_any && !refilling;
        rsp_rdata = way_word[hit_way*C2W_DW +: C2W_DW];
        mem_wdata = req_wdata;
        if (refilling) begin
            mem_addr = {req_addr[ADDR_W-1:OFF_W], fill_word, 2'b00};
            mem_be   = '1;
        end else begin
            mem_addr = {req_addr[ADDR_W-1:2], 2'b00};
            mem_be   = req_be;
        end
    end

    if (DCACHE) begin : g_hold_data
        assign stall_stages = {1'b0, {(NSTAGE-1){stall}}};
    end else begin : g_hold_fetch
        assign stall_stages = {{(NSTAGE-1){1'b0}}, stall};
    end
endmodule

// File: rtl/c2w_checker.sv
module c2w_checker #(
    parameter int ADDR_W = 32,
    parameter int NSTAGE = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              hit_any,
    input logic              refilling,
    input logic              stall,
    input logic [NSTAGE-1:0] stall_stages,
    input logic              mem_valid,
    input logic              mem_write,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr
);
    p_hit_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!refilling && req_valid && !req_write && hit_any) |-> !stall);

    p_miss_enters_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!refilling && req_valid && !req_write && !hit_any) |=> (refilling && stall));

    p_fill_is_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        refilling |-> (mem_valid && !mem_write));

    p_fill_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (refilling && !mem_ready) |=> $stable(mem_addr));

    p_store_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!refilling && req_valid && req_write) |-> (mem_valid && mem_write));

    p_fetch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> stall_stages[0]);
endmodule

bind c2w_cache c2w_checker #(.ADDR_W(ADDR_W), .NSTAGE(NSTAGE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .hit_any      (hit_any),
    .refilling    (refilling),
    .stall        (stall),
    .stall_stages (stall_stages),
    .mem_valid    (mem_valid),
    .mem_write    (mem_write),
    .mem_ready    (mem_ready),
    .mem_addr     (mem_addr)
);

// File: tb/c2w_cache_test.sv
`timescale 1ns/1ps
module c2w_cache_test;
    localparam int IDX_W  = 4;
    localparam int SETS   = 1 << IDX_W;
    localparam int NSTAGE = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid, stall, mem_valid, mem_write;
    logic [31:0] rsp_rdata, mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [NSTAGE-1:0] stall_stages, f_stages;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        f_rv, f_st, f_mv, f_mw;
    logic [31:0] f_rd, f_ma, f_wd;
    logic [3:0]  f_be;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] mem_m [logic [29:0]];
    bit          m_valid [2][SETS];
    logic [31:0] m_tag   [2][SETS];
    logic [31:0] m_data  [2][SETS][2];
    bit          m_lru   [SETS];

    always #10 clk = ~clk;

    c2w_cache #(.IDX_W(IDX_W), .NSTAGE(NSTAGE), .DCACHE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .stall(stall),
        .stall_stages(stall_stages), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata));

    c2w_cache #(.IDX_W(IDX_W), .NSTAGE(NSTAGE), .DCACHE(1'b0)) uut_fetch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(f_rv), .rsp_rdata(f_rd), .stall(f_st),
        .stall_stages(f_stages), .mem_valid(f_mv), .mem_write(f_mw),
        .mem_addr(f_ma), .mem_wdata(f_wd), .mem_be(f_be),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem_m.exists(a[31:2])) return mem_m[a[31:2]];
        return {~a[15:0], a[15:0]};
    endfunction

    function automatic int set_of(input logic [31:0] a);
        return int'((a >> 3) & (SETS - 1));
    endfunction

    function automatic int find_way(input logic [31:0] a);
        int s = set_of(a);
        for (int w = 0; w < 2; w++)
            if (m_valid[w][s] && m_tag[w][s] == (a >> (3 + IDX_W))) return w;
        return -1;
    endfunction

    task automatic idle_check();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; mem_ready = 1'b0;
        #1;
        chk(!stall && !mem_valid, "R1 idle quiet", {stall, mem_valid}, 0);
        @(posedge clk);
    endtask

    task automatic do_read(input logic [31:0] a, input int exp_hit, input int d0, input int d1, input string lbl);
        int s = set_of(a);
        int way = find_way(a);
        int v;
        int dl;
        logic [31:0] la;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1;
        if (exp_hit >= 0)
            chk(stall == (exp_hit == 0), lbl, stall, exp_hit == 0);
        if (way >= 0) begin
            chk(!stall && rsp_valid, "R2 hit no stall", {stall, rsp_valid}, 1);
            chk(rsp_rdata == m_data[way][s][a[2]], "R2 hit data", rsp_rdata, m_data[way][s][a[2]]);
            m_lru[s] = (way == 0);
            @(posedge clk);
        end else begin
            chk(stall, "R3 miss stall", stall, 1);
            v = !m_valid[0][s] ? 0 : (!m_valid[1][s] ? 1 : int'(m_lru[s]));
            @(posedge clk);
            for (int wd = 0; wd < 2; wd++) begin
                dl = (wd == 0) ? d0 : d1;
                la = {a[31:3], wd[0], 2'b00};
                for (int k = 0; k <= dl; k++) begin
                    @(negedge clk);
                    mem_ready = (k == dl);
                    mem_rdata = mem_rd(la);
                    #1;
                    chk(mem_valid && !mem_write && mem_be == 4'hf, "R4 fill read", {mem_valid, mem_write, mem_be}, 32'h2f);
                    chk(mem_addr == la, "R4 fill addr", mem_addr, la);
                    chk(stall, "R3 held stall", stall, 1);
                    chk(stall_stages == 5'b01111, "R8 data hold", stall_stages, 5'b01111);
                    chk(f_stages == 5'b00001, "R8 fetch hold", f_stages, 5'b00001);
                    @(posedge clk);
                end
                m_data[v][s][wd] = la == a ? mem_rd(la) : mem_rd(la);
            end
            m_valid[v][s] = 1;
            m_tag[v][s] = a >> (3 + IDX_W);
            m_lru[s] = (v == 0);
            @(negedge clk);
            mem_ready = 1'b0;
            #1;
            chk(!stall && rsp_valid, "R3 release", {stall, rsp_valid}, 1);
            chk(rsp_rdata == m_data[v][s][a[2]], "R3 refill data", rsp_rdata, m_data[v][s][a[2]]);
            chk(stall_stages == 5'b00000, "R8 data release", stall_stages, 0);
            @(posedge clk);
        end
        idle_check();
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input int dl);
        int s = set_of(a);
        int way = find_way(a);
        logic [31:0] old;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        for (int k = 0; k <= dl; k++) begin
            if (k > 0) @(negedge clk);
            mem_ready = (k == dl);
            #1;
            chk(mem_valid && mem_write, "R5 store issued", {mem_valid, mem_write}, 3);
            chk(mem_addr == a && mem_wdata == d && mem_be == be, "R5 store fields", mem_addr, a);
            chk(stall == (k != dl), "R5 store stall", stall, k != dl);
            @(posedge clk);
        end
        old = mem_rd(a);
        for (int b = 0; b < 4; b++) if (be[b]) old[8*b +: 8] = d[8*b +: 8];
        mem_m[a[31:2]] = old;
        if (way >= 0) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) m_data[way][s][a[2]][8*b +: 8] = d[8*b +: 8];
            m_lru[s] = (way == 0);
        end
        idle_check();
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_lru[s] = 0;
            for (int w = 0; w < 2; w++) m_valid[w][s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!stall && !mem_valid && stall_stages == 0, "R1 reset state", {stall, mem_valid}, 0);
        // A, B, C share set 0 (R9 index bits [6:3]); E, F set 1; G set 2
        do_read(32'h0000_0100, 0, 0, 2, "R1 first read misses");
        do_read(32'h0000_0104, 1, 0, 0, "R2 word 1 hit");
        do_read(32'h0000_0100, 1, 0, 0, "R2 word 0 hit");
        do_read(32'h0000_0200, 0, 1, 0, "R7 second way fill");
        do_read(32'h0000_0100, 1, 0, 0, "R7 touch way 0");
        do_read(32'h0000_0300, 0, 3, 1, "R7 evict LRU");
        do_read(32'h0000_0100, 1, 0, 0, "R7 recent line kept");
        do_read(32'h0000_0204, 0, 0, 0, "R7 evicted line misses");
        do_read(32'h0000_0108, 0, 2, 2, "R9 other set miss");
        do_write(32'h0000_010C, 32'hDEAD_BEEF, 4'b0011, 2);
        do_read(32'h0000_010C, 1, 0, 0, "R6 store hit merged");
        do_write(32'h0000_0208, 32'h1234_5678, 4'b1111, 0);
        do_read(32'h0000_0208, 0, 1, 1, "R6 store miss no allocate");
        do_read(32'h0000_0110, 0, 0, 0, "R9 third set miss");
        do_read(32'h0000_0108, 1, 0, 0, "R9 set 1 unaffected");
        do_write(32'h0000_0110, 32'hA5A5_5A5A, 4'b1001, 1);
        do_read(32'h0000_0110, 1, 0, 0, "R6 second merge");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule